// File: doc/BRIEF.md
# Banked Physical Address Mapper

This block turns a 16-bit logical address into a 19-bit physical address for a 512 KB byte-wide memory. The memory is seen as eight 64 KB banks, and each bank holds four 16 KB blocks. A microcode word supplies a 3-bit mode, a 3-bit bank field and a code/data indicator. The mode decides where the upper address bits come from.

Two small bank-select registers give software-controlled banking. The program register holds a bank and a block number. The data register holds a bank number. Both registers load from a shared write value on their own write strobes.

The address path is purely combinational from the inputs and the registered bank state, so a translation is available in the same cycle that the logical address is presented. The block also raises an error flag when a code fetch falls in the region that kernel-slot3 mode remaps, because code must not be fetched from that region.

Top module: `banked_addr_mapper`

## Requirements
- R1: After reset both bank-select registers hold zero, so application mode (mode 3) maps logical 0x1234 to physical 0x01234, and `fetch_err` is low.
- R2: Mode 0 (register) outputs the low 8 logical bits with all upper physical bits zero, whatever the values of the bank registers and of `uc_bank`.
- R3: Mode 1 (table/zero-page) outputs {0, uc_bank[1:0], eight zeros, laddr[7:0]}. With uc_bank[1:0]=00 this gives the same result as register mode.
- R4: Mode 2 (native) outputs {0, uc_bank[1:0], laddr}. Physical bit 18 is zero and uc_bank[2] has no effect.
- R5: Mode 3 (application) outputs {prog_bank, laddr} for code fetches and for data accesses alike.
- R6: Mode 4 (kernel-slot1) maps laddr 0x4000–0x7FFF to {prog_bank, prog_block, laddr[13:0]}. All other addresses map to {uc_bank, laddr}.
- R7: Mode 5 (kernel-slot3) maps laddr 0xC000–0xFFFF to {data_bank, 2'b11, laddr[13:0]}. All other addresses map to {uc_bank, laddr}.
- R8: `fetch_err` is high only when mode is 5, `is_code` is 1 and laddr[15:14]=11. It is low in every other case, including code fetches from slot 1 in mode 4.
- R9: Mode 6 (linear) gives code fetches {prog_bank[2:1], uc_bank[0], laddr} and data accesses {data_bank, laddr}.
- R10: A high `wr_prog` at a clock edge loads prog_bank=wr_value[4:2] and prog_block=wr_value[1:0]. A high `wr_data` loads data_bank=wr_value[4:2]. The new value takes effect from the next cycle, and a register without its strobe keeps its value.
- R11: Mode 7 is unassigned and behaves like register mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| laddr | input | 16 | Logical address |
| is_code | input | 1 | 1 = instruction fetch, 0 = data access |
| mode | input | 3 | Microcode addressing mode (0..7) |
| uc_bank | input | 3 | Microcode bank field |
| wr_prog | input | 1 | Load strobe for the program bank register |
| wr_data | input | 1 | Load strobe for the data bank register |
| wr_value | input | 5 | Write value: [4:2] bank, [1:0] block |
| paddr | output | 19 | Physical address |
| fetch_err | output | 1 | Illegal code fetch from the remapped slot 3 |

## Verification
A bank-register write and a translation that depends on that register can occur in the same cycle. The bench presents an application-mode address while `wr_prog` is high and checks, before the clock edge, that the output still uses the old bank. On the next cycle it checks that the output uses the new bank. It also checks that a code fetch in kernel-slot3 produces the remapped address and the error flag together, in the same cycle.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
    localparam int LA_W       = 16;
    localparam int PA_W       = 19;
    localparam int BANK_W     = PA_W - LA_W;
    localparam int BLK_W      = 2;
    localparam int ZP_W       = 8;
    localparam int SLOT_N     = 1 << BLK_W;
    localparam int SLOT_LOW_W = LA_W - BLK_W;
    localparam int WV_W       = BANK_W + BLK_W;

    typedef enum logic [2:0] {
        MODE_REG = 3'd0,
        MODE_TBL = 3'd1,
        MODE_NAT = 3'd2,
        MODE_APP = 3'd3,
        MODE_KS1 = 3'd4,
        MODE_KS3 = 3'd5,
        MODE_LIN = 3'd6,
        MODE_RSV = 3'd7
    } map_mode_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [BLK_W-1:0]  blk;
    } prog_sel_t;
endpackage

// File: rtl/bank_select_regs.sv
module bank_select_regs
    import addr_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_prog,
    input  logic              wr_data,
    input  logic [WV_W-1:0]   wr_value,
    output prog_sel_t         prog_sel,
    output logic [BANK_W-1:0] data_bank
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_sel <= '0;
        end else if (wr_prog) begin
            prog_sel <= prog_sel_t'(wr_value);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_bank <= '0;
        end else if (wr_data) begin
            data_bank <= wr_value[WV_W-1:BLK_W];
        end
    end

    // R10: load takes one clock, holds otherwise
    a_r10_prog_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prog |=> (prog_sel == prog_sel_t'($past(wr_value))));
    a_r10_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (data_bank == $past(wr_value[WV_W-1:BLK_W])));
    a_r10_prog_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_prog |=> $stable(prog_sel));
    a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(data_bank));
endmodule

// File: rtl/slot_decoder.sv
module slot_decoder
    import addr_map_pkg::*;
(
    input  logic [BLK_W-1:0]  slot,
    output logic [SLOT_N-1:0] slot_hit
);
    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        assign slot_hit[g] = (slot == BLK_W'(g));
    end
endmodule

// File: rtl/upper_addr_select.sv
module upper_addr_select
    import addr_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  map_mode_e         mode,
    input  logic [LA_W-1:0]   laddr,
    input  logic              is_code,
    input  logic [BANK_W-1:0] uc_bank,
    input  prog_sel_t         prog_sel,
    input  logic [BANK_W-1:0] data_bank,
    input  logic [SLOT_N-1:0] slot_hit,
    output logic [PA_W-1:0]   paddr,
    output logic              fetch_err
);
    localparam int UC_LO_W = BANK_W - 1;

    logic [PA_W-1:0] low_page;

    assign low_page = {{(PA_W-ZP_W){1'b0}}, laddr[ZP_W-1:0]};

    always_comb begin
        paddr     = low_page;
        fetch_err = 1'b0;
        unique case (mode)
            MODE_REG: paddr = low_page;
            MODE_TBL: paddr = {1'b0, uc_bank[UC_LO_W-1:0],
                               {(LA_W-ZP_W){1'b0}}, laddr[ZP_W-1:0]};
            MODE_NAT: paddr = {1'b0, uc_bank[UC_LO_W-1:0], laddr};
            MODE_APP: paddr = {prog_sel.bank, laddr};
            MODE_KS1: begin
                if (slot_hit[1])
                    paddr = {prog_sel.bank, prog_sel.blk, laddr[SLOT_LOW_W-1:0]};
                else
                    paddr = {uc_bank, laddr};
            end
            MODE_KS3: begin
                if (slot_hit[SLOT_N-1]) begin
                    paddr     = {data_bank, {BLK_W{1'b1}}, laddr[SLOT_LOW_W-1:0]};
                    fetch_err = is_code;
                end else begin
                    paddr = {uc_bank, laddr};
                end
            end
            MODE_LIN: begin
                if (is_code)
                    paddr = {prog_sel.bank[BANK_W-1:1], uc_bank[0], laddr};
                else
                    paddr = {data_bank, laddr};
            end
            MODE_RSV: paddr = low_page;
            default:  paddr = low_page;
        endcase
    end

    // R2 / R11: register-like modes never leave the lowest page
    a_r2_reg_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REG || mode == MODE_RSV) |-> (paddr[PA_W-1:ZP_W] == '0));
    // R4: native never sets the top physical bit
    a_r4_nat_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NAT) |-> !paddr[PA_W-1]);
    // R8: error only for code fetches in kernel-slot3
    a_r8_err_scope: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_err |-> (mode == MODE_KS3 && is_code && laddr[LA_W-1] && laddr[LA_W-2]));
    // R6: slot 1 keeps the offset inside the block
    a_r6_slot_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_KS1) |-> (paddr[SLOT_LOW_W-1:0] == laddr[SLOT_LOW_W-1:0]));
    // R7: remapped slot 3 always lands in block 3
    a_r7_block3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_KS3 && slot_hit[SLOT_N-1]) |-> (paddr[LA_W-1:SLOT_LOW_W] == '1));
endmodule

// File: rtl/banked_addr_mapper.sv
module banked_addr_mapper
    import addr_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] laddr,
    input  logic        is_code,
    input  logic [2:0]  mode,
    input  logic [2:0]  uc_bank,
    input  logic        wr_prog,
    input  logic        wr_data,
    input  logic [4:0]  wr_value,
    output logic [18:0] paddr,
    output logic        fetch_err
);
    prog_sel_t         prog_sel;
    logic [BANK_W-1:0] data_bank;
    logic [SLOT_N-1:0] slot_hit;

    bank_select_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_prog   (wr_prog),
        .wr_data   (wr_data),
        .wr_value  (wr_value),
        .prog_sel  (prog_sel),
        .data_bank (data_bank)
    );

    slot_decoder i_slots (
        .slot     (laddr[LA_W-1:SLOT_LOW_W]),
        .slot_hit (slot_hit)
    );

    upper_addr_select i_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (map_mode_e'(mode)),
        .laddr     (laddr),
        .is_code   (is_code),
        .uc_bank   (uc_bank),
        .prog_sel  (prog_sel),
        .data_bank (data_bank),
        .slot_hit  (slot_hit),
        .paddr     (paddr),
        .fetch_err (fetch_err)
    );
endmodule

// File: tb/test_banked_addr_mapper.sv
module test_banked_addr_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] laddr = '0;
    logic        is_code = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  uc_bank = '0;
    logic        wr_prog = 1'b0;
    logic        wr_data = 1'b0;
    logic [4:0]  wr_value = '0;
    logic [18:0] paddr;
    logic        fetch_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [18:0] pa;
        logic        err;
        string       tag;
    } exp_t;
    exp_t q[$];
    event ev_chk;

    always #4 clk = ~clk;

    banked_addr_mapper i_banked_addr_mapper (
        .clk(clk), .rst_n(rst_n), .laddr(laddr), .is_code(is_code),
        .mode(mode), .uc_bank(uc_bank), .wr_prog(wr_prog), .wr_data(wr_data),
        .wr_value(wr_value), .paddr(paddr), .fetch_err(fetch_err)
    );

    // monitor: pops expected items and compares
    initial begin
        forever begin
            @(ev_chk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (paddr !== e.pa || fetch_err !== e.err) begin
                    bad++;
                    $display("FAIL %s: paddr=%05h err=%0b expected paddr=%05h err=%0b",
                             e.tag, paddr, fetch_err, e.pa, e.err);
                end
            end
        end
    end

    task automatic drive(input logic [2:0] m, input logic [15:0] a, input logic c,
                         input logic [2:0] u, input logic [18:0] epa,
                         input logic eerr, input string tag);
        @(negedge clk);
        mode = m; laddr = a; is_code = c; uc_bank = u;
        q.push_back('{epa, eerr, tag});
        ->ev_chk;
    endtask

    task automatic write_regs(input logic p, input logic d, input logic [4:0] v);
        @(negedge clk);
        wr_prog = p; wr_data = d; wr_value = v;
        @(negedge clk);
        wr_prog = 1'b0; wr_data = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        drive(3'd3, 16'h1234, 1'b0, 3'd0, 19'h01234, 1'b0, "R1 reset bank zero");

        // R10 same-cycle write: old bank still used before the edge
        @(negedge clk);
        wr_prog = 1'b1; wr_value = 5'b101_10;
        mode = 3'd3; laddr = 16'hABCD; is_code = 1'b1; uc_bank = 3'd0;
        q.push_back('{19'h0ABCD, 1'b0, "R10 old bank during write"});
        ->ev_chk;
        @(negedge clk);
        wr_prog = 1'b0;
        q.push_back('{19'h5ABCD, 1'b0, "R10 new bank after write"});
        ->ev_chk;
        // data register write only; program register must hold
        write_regs(1'b0, 1'b1, 5'b011_00);
        drive(3'd3, 16'h0010, 1'b0, 3'd0, 19'h50010, 1'b0, "R10 prog holds, R5 app data");

        // R2 register mode
        drive(3'd0, 16'hBEEF, 1'b1, 3'd7, 19'h000EF, 1'b0, "R2 register mode");
        // R3 table mode
        drive(3'd1, 16'h12A5, 1'b0, 3'b110, 19'h200A5, 1'b0, "R3 table A17");
        drive(3'd1, 16'h12A5, 1'b0, 3'b100, 19'h000A5, 1'b0, "R3 table 00 like register");
        // R4 native
        drive(3'd2, 16'h8001, 1'b0, 3'd7, 19'h38001, 1'b0, "R4 native top bit zero");
        // R5 application code
        drive(3'd3, 16'hF000, 1'b1, 3'd2, 19'h5F000, 1'b0, "R5 app code");
        // R6 kernel slot1
        drive(3'd4, 16'h4567, 1'b0, 3'd2, 19'h58567, 1'b0, "R6 slot1 remap");
        drive(3'd4, 16'h7FFF, 1'b1, 3'd2, 19'h5BFFF, 1'b0, "R6 slot1 top edge, R8 no err");
        drive(3'd4, 16'h3FFF, 1'b0, 3'd2, 19'h23FFF, 1'b0, "R6 slot0 microcode bank");
        drive(3'd4, 16'h8567, 1'b0, 3'd2, 19'h28567, 1'b0, "R6 slot2 microcode bank");
        // R7 / R8 kernel slot3
        drive(3'd5, 16'hC123, 1'b0, 3'd1, 19'h3C123, 1'b0, "R7 slot3 data remap");
        drive(3'd5, 16'hC123, 1'b1, 3'd1, 19'h3C123, 1'b1, "R8 slot3 code fetch error");
        drive(3'd5, 16'hBFFF, 1'b1, 3'd1, 19'h1BFFF, 1'b0, "R7 slot2 code no error");
        // R9 linear
        drive(3'd6, 16'h1000, 1'b1, 3'd0, 19'h41000, 1'b0, "R9 linear code A16=0");
        drive(3'd6, 16'h1000, 1'b1, 3'd1, 19'h51000, 1'b0, "R9 linear code A16=1");
        drive(3'd6, 16'h1000, 1'b0, 3'd1, 19'h31000, 1'b0, "R9 linear data");
        // R11 unassigned mode
        drive(3'd7, 16'hBEEF, 1'b1, 3'd5, 19'h000EF, 1'b0, "R11 mode 7 like register");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule